// File: doc/BRIEF.md
# Per-Core Two-Stage Tick Timer

This block is the local tick timer of one processor core. A prescale down-counter divides the input clock: loaded with a tick-buffer value N, it emits one tick every N+1 clock cycles. Each tick decrements a 31-bit interrupt counter. When that counter expires, the block sets an interrupt status bit, and the interrupt output follows it when the interrupt enable bit is set.

In interval mode the interrupt counter reloads from its buffer on every expiry, so interrupts repeat until software stops the counters. Without interval mode the interrupt counter stops after one expiry. Software programs both buffers, starts the tick stage and the interrupt stage with separate control bits, and sees each write to a buffer or to the control register acknowledged by a sticky write-status bit that it clears by writing 1.

The block decodes only its own 256-byte register bank. The bank starts at 0x300 + 0x100 × core index. Reads return data in the same cycle, and every write takes effect at the clock edge on which it is presented.

Top module: `core_tick_timer`

## Requirements
- R1: Only addresses in page 3 + CORE_IDX (address bits 11:8) reach the registers. Writes to any other page change nothing, and reads from another page return 0.
- R2: The tick buffer (offset 0x00) holds N. While the tick stage runs, a tick occurs every N+1 clock cycles, so with an interrupt count of 1 the interrupt period is N+1 cycles.
- R3: A write to the interrupt buffer (offset 0x08) takes effect only when bit 31 is set. Bits 30:0 are then stored and loaded into the interrupt counter. A write with bit 31 clear leaves the buffer unchanged, and reads return bits 30:0 with bit 31 as 0.
- R4: Control (offset 0x20) bit 0 runs the tick stage and bit 1 runs the interrupt stage. Setting a run bit from 0 loads that counter from its buffer. The status bit is set M×(N+1) cycles after the write that starts both stages, where M is the interrupt count and a count of 0 behaves as 1.
- R5: With control bit 2 (interval) set, interrupts repeat every M×(N+1) cycles.
- R6: With control bit 2 clear, exactly one expiry occurs, and no further one follows until a counter is restarted.
- R7: Interrupt status bit 0 (offset 0x30) is set on expiry whether or not the interrupt is enabled. Writing 1 to it clears it, and writing 0 has no effect.
- R8: The irq output is high exactly when status bit 0 and enable bit 0 (offset 0x34) are both set.
- R9: Write-status (offset 0x40) bit 0 is set by a tick-buffer write, bit 1 by an interrupt-buffer write (with or without bit 31) and bit 3 by a control write. Each bit stays set until a 1 is written to it.
- R10: Clearing the run bits freezes the counters and leaves the buffers unchanged. Setting them again restarts a full period.
- R11: After reset every register reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq | output | 1 | Tick interrupt request |

## Verification
The hardest situation to reach is a counter halted in the middle of a period and then restarted. From the ports this is only visible as a change in interrupt timing, so the bench times writes to the control register a known number of cycles after a start. It then checks that nothing fires while the stages are stopped and that a restart gives a full period again. The interval and one-shot behaviour are told apart by timing irq edges against a free-running cycle count, and a sweep over small tick and interrupt counts checks the M×(N+1) period arithmetically, including an interrupt count of 0.

// File: rtl/ctt_pkg.sv
// Package: shared constants and types for the per-core tick timer.
// Assumes a 32-bit data path and a 12-bit byte address with 256-byte banks.
package ctt_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int ICNT_W    = DATA_W - 1;
    localparam int FIRST_PAGE = 3;

    localparam logic [7:0] OFS_TBUF  = 8'h00;
    localparam logic [7:0] OFS_IBUF  = 8'h08;
    localparam logic [7:0] OFS_CTRL  = 8'h20;
    localparam logic [7:0] OFS_ISTAT = 8'h30;
    localparam logic [7:0] OFS_IEN   = 8'h34;
    localparam logic [7:0] OFS_WSTAT = 8'h40;

    localparam int WS_TBUF = 0;
    localparam int WS_IBUF = 1;
    localparam int WS_CTRL = 3;

    typedef struct packed {
        logic auto_rl;
        logic irun;
        logic trun;
    } ctrl_t;
endpackage

// File: rtl/ctt_tick.sv
// Module: prescale stage. Counts down from the tick buffer and emits one
// tick per N+1 cycles while running. Assumes load and run are never both
// high, because a start always comes from a stopped state.
module ctt_tick #(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic [TICK_W-1:0] seed,
    output logic              tick
);
    logic [TICK_W-1:0] cnt;

    assign tick = run && !load && (cnt == '0);

    // Down-counter with reload on terminal count or on start.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (load)            cnt <= seed;
        else if (run) begin
            if (cnt == '0)        cnt <= seed;
            else                  cnt <= cnt - 1'b1;
        end
    end

    p_tick_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(seed)));
    p_tick_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/ctt_intcnt.sv
// Module: interrupt stage. Decrements once per tick and flags an expiry on
// the tick that finds the count at 1 or 0. It then reloads in interval mode
// and otherwise parks until the next load.
module ctt_intcnt #(
    parameter int ICNT_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              auto_rl,
    input  logic              load,
    input  logic [ICNT_W-1:0] seed,
    input  logic              tick,
    output logic              expire
);
    logic [ICNT_W-1:0] cnt;
    logic              done;
    logic              step;

    assign step   = run && tick && !done && !load;
    assign expire = step && (cnt <= ICNT_W'(1));

    // Counter and one-shot park flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (load) begin
            cnt  <= seed;
            done <= 1'b0;
        end else if (step) begin
            if (cnt <= ICNT_W'(1)) begin
                cnt  <= auto_rl ? seed : '0;
                done <= !auto_rl;
            end else begin
                cnt  <= cnt - 1'b1;
            end
        end
    end

    p_oneshot_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !auto_rl) |=> !expire);
    p_interval_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && auto_rl) |=> (cnt == $past(seed)));
    p_int_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/ctt_regs.sv
// Module: register bank of one core. It decodes its own page and holds the
// buffers, control, interrupt status and enable, and the sticky write-status
// bits. Start pulses go out when a run bit goes from 0 to 1. Assumes one
// access per cycle.
module ctt_regs
    import ctt_pkg::*;
#(
    parameter int CORE_IDX = 0,
    parameter int TICK_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              expire,
    output logic [TICK_W-1:0] tbuf,
    output logic [ICNT_W-1:0] int_seed,
    output ctrl_t             ctrl,
    output logic              tick_load,
    output logic              int_load,
    output logic              irq
);
    localparam logic [ADDR_W-9:0] PAGE = (ADDR_W-8)'(FIRST_PAGE + CORE_IDX);

    logic              hit;
    logic [7:0]        ofs;
    logic              wr_tbuf, wr_ibuf, wr_ctrl, wr_istat, wr_ien, wr_wstat;
    logic              ibuf_upd;
    logic [ICNT_W-1:0] ibuf;
    logic              istat, ien;
    logic [3:0]        wstat;
    ctrl_t             wctrl;

    assign hit      = (bus_addr[ADDR_W-1:8] == PAGE);
    assign ofs      = bus_addr[7:0];
    assign wr_tbuf  = bus_wr && hit && (ofs == OFS_TBUF);
    assign wr_ibuf  = bus_wr && hit && (ofs == OFS_IBUF);
    assign wr_ctrl  = bus_wr && hit && (ofs == OFS_CTRL);
    assign wr_istat = bus_wr && hit && (ofs == OFS_ISTAT);
    assign wr_ien   = bus_wr && hit && (ofs == OFS_IEN);
    assign wr_wstat = bus_wr && hit && (ofs == OFS_WSTAT);
    assign wctrl    = bus_wdata[2:0];

    assign ibuf_upd  = wr_ibuf && bus_wdata[DATA_W-1];
    assign int_seed  = ibuf_upd ? bus_wdata[ICNT_W-1:0] : ibuf;
    assign tick_load = wr_ctrl && wctrl.trun && !ctrl.trun;
    assign int_load  = (wr_ctrl && wctrl.irun && !ctrl.irun) || ibuf_upd;
    assign irq       = istat && ien;

    // Buffers, control and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbuf <= '0;
            ibuf <= '0;
            ctrl <= '0;
            ien  <= 1'b0;
        end else begin
            if (wr_tbuf)  tbuf <= bus_wdata[TICK_W-1:0];
            if (ibuf_upd) ibuf <= bus_wdata[ICNT_W-1:0];
            if (wr_ctrl)  ctrl <= wctrl;
            if (wr_ien)   ien  <= bus_wdata[0];
        end
    end

    // Interrupt status: a new expiry wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       istat <= 1'b0;
        else if (expire)                  istat <= 1'b1;
        else if (wr_istat && bus_wdata[0]) istat <= 1'b0;
    end

    // Sticky write acknowledges, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wstat <= '0;
        end else begin
            if (wr_wstat) wstat <= wstat & ~bus_wdata[3:0] & 4'b1011;
            if (wr_tbuf)  wstat[WS_TBUF] <= 1'b1;
            if (wr_ibuf)  wstat[WS_IBUF] <= 1'b1;
            if (wr_ctrl)  wstat[WS_CTRL] <= 1'b1;
        end
    end

    // Same-cycle read mux; other pages and unused offsets read zero.
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (ofs)
                OFS_TBUF:  bus_rdata = DATA_W'(tbuf);
                OFS_IBUF:  bus_rdata = DATA_W'(ibuf);
                OFS_CTRL:  bus_rdata = DATA_W'(ctrl);
                OFS_ISTAT: bus_rdata = DATA_W'(istat);
                OFS_IEN:   bus_rdata = DATA_W'(ien);
                OFS_WSTAT: bus_rdata = DATA_W'(wstat);
                default:   bus_rdata = '0;
            endcase
        end
    end

    p_ibuf_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ibuf && !bus_wdata[DATA_W-1]) |=> $stable(ibuf));
    p_istat_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> istat);
    p_wstat_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wstat[WS_CTRL] && !(wr_wstat && bus_wdata[WS_CTRL])) |=> wstat[WS_CTRL]);
    p_foreign_page_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !hit) |=> ($stable(tbuf) && $stable(ibuf) && $stable(ctrl)));
endmodule

// File: rtl/core_tick_timer.sv
// Module: top of the per-core tick timer. It joins the register bank, the
// prescale stage and the interrupt stage. Assumes a single clock domain and
// a synchronous active-low reset.
module core_tick_timer #(
    parameter int CORE_IDX = 0,
    parameter int TICK_W   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    import ctt_pkg::*;

    logic              expire, tick, tick_load, int_load;
    logic [TICK_W-1:0] tbuf;
    logic [ICNT_W-1:0] int_seed;
    ctrl_t             ctrl;

    ctt_regs #(.CORE_IDX(CORE_IDX), .TICK_W(TICK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire(expire),
        .tbuf(tbuf), .int_seed(int_seed), .ctrl(ctrl),
        .tick_load(tick_load), .int_load(int_load), .irq(irq)
    );

    ctt_tick #(.TICK_W(TICK_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(ctrl.trun), .load(tick_load),
        .seed(tbuf), .tick(tick)
    );

    ctt_intcnt #(.ICNT_W(ICNT_W)) u_int (
        .clk(clk), .rst_n(rst_n), .run(ctrl.irun), .auto_rl(ctrl.auto_rl),
        .load(int_load), .seed(int_seed), .tick(tick), .expire(expire)
    );

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(expire) || $past(bus_wr)));
endmodule

// File: tb/tb_core_tick_timer.sv
module tb_core_tick_timer;
    localparam int CORE = 1;
    localparam logic [11:0] BASE  = 12'h400;
    localparam logic [11:0] OTHER = 12'h300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    bit          finished = 1'b0;

    core_tick_timer #(.CORE_IDX(CORE), .TICK_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Waits at falling edges for irq; returns cycles elapsed since t0.
    task automatic wait_irq(input int t0, input int lim, output int dt);
        int n = 0;
        while (!irq && n < lim) begin
            @(negedge clk);
            n++;
        end
        dt = irq ? (cyc - t0) : -1;
    endtask

    task automatic arm(input int n, input int m, input logic [2:0] c, output int t0);
        wr(BASE + 12'h20, 0);
        wr(BASE + 12'h30, 1);
        wr(BASE + 12'h00, n);
        wr(BASE + 12'h08, 32'h8000_0000 | m);
        wr(BASE + 12'h34, 1);
        wr(BASE + 12'h20, {29'd0, c});
        t0 = cyc;
    endtask

    initial begin
        logic [31:0] d;
        int t0, t1, dt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        check("R11 irq", irq, 0);
        foreach (d[i]) ;
        for (int o = 0; o < 6; o++) begin
            logic [7:0] ofs [6] = '{8'h00, 8'h08, 8'h20, 8'h30, 8'h34, 8'h40};
            rd(BASE + {4'd0, ofs[o]}, d);
            check("R11 reg", d, 0);
        end

        // R3: update flag in bit 31
        wr(BASE + 12'h08, 32'h8000_0005); rd(BASE + 12'h08, d); check("R3 set", d, 5);
        wr(BASE + 12'h08, 32'h0000_0007); rd(BASE + 12'h08, d); check("R3 ignore", d, 5);
        wr(BASE + 12'h08, 32'hFFFF_FFFF); rd(BASE + 12'h08, d); check("R3 max", d, 32'h7FFF_FFFF);

        // R1: foreign pages
        wr(BASE + 12'h00, 32'h11);
        wr(OTHER + 12'h00, 32'h55); rd(BASE + 12'h00, d); check("R1 foreign write", d, 32'h11);
        wr(12'h500, 32'h66); rd(BASE + 12'h00, d); check("R1 foreign write hi", d, 32'h11);
        rd(OTHER + 12'h00, d); check("R1 foreign read", d, 0);

        // R9: sticky write status
        wr(BASE + 12'h40, 32'hF); rd(BASE + 12'h40, d); check("R9 clear all", d, 0);
        wr(BASE + 12'h00, 3); rd(BASE + 12'h40, d); check("R9 tbuf", d, 1);
        wr(BASE + 12'h08, 3); rd(BASE + 12'h40, d); check("R9 ibuf", d, 3);
        wr(BASE + 12'h20, 0); rd(BASE + 12'h40, d); check("R9 ctrl", d, 32'hB);
        wr(BASE + 12'h40, 2); rd(BASE + 12'h40, d); check("R9 clear one", d, 32'h9);
        wr(BASE + 12'h40, 0); rd(BASE + 12'h40, d); check("R9 write zero", d, 32'h9);

        // R2 and R4: period sweep M*(N+1), count 0 acts as 1
        for (int n = 0; n < 6; n++) begin
            for (int m = 0; m < 5; m++) begin
                arm(n, m, 3'b011, t0);
                wait_irq(t0, 200, dt);
                check(m == 1 ? "R2 tick period" : "R4 first expiry", dt,
                      (m == 0 ? 1 : m) * (n + 1));
            end
        end

        // R5: interval mode repeats
        arm(2, 3, 3'b111, t0);
        wait_irq(t0, 200, dt); check("R5 first", dt, 9);
        t1 = cyc;
        for (int k = 0; k < 3; k++) begin
            wr(BASE + 12'h30, 1);
            check("R7 cleared", irq, 0);
            wait_irq(t1, 200, dt); check("R5 repeat", dt, 9);
            t1 = cyc;
        end

        // R6: one-shot fires once
        arm(2, 3, 3'b011, t0);
        wait_irq(t0, 200, dt); check("R6 first", dt, 9);
        wr(BASE + 12'h30, 1);
        t1 = cyc;
        wait_irq(t1, 40, dt); check("R6 no repeat", dt, -1);

        // R7 and R8: status independent of enable
        arm(1, 2, 3'b011, t0);
        wr(BASE + 12'h34, 0);
        repeat (8) @(negedge clk);
        check("R8 masked", irq, 0);
        rd(BASE + 12'h30, d); check("R7 set while masked", d, 1);
        wr(BASE + 12'h34, 1); check("R8 enabled", irq, 1);
        wr(BASE + 12'h30, 0); check("R7 write zero", irq, 1);
        wr(BASE + 12'h30, 1); check("R7 write one", irq, 0);

        // R10: halt mid-period, buffers kept, restart gives full period
        arm(2, 3, 3'b011, t0);
        repeat (4) @(negedge clk);
        wr(BASE + 12'h20, 0);
        t1 = cyc;
        wait_irq(t1, 30, dt); check("R10 halted", dt, -1);
        rd(BASE + 12'h00, d); check("R10 tbuf kept", d, 2);
        rd(BASE + 12'h08, d); check("R10 ibuf kept", d, 3);
        wr(BASE + 12'h20, 3);
        t0 = cyc;
        wait_irq(t0, 200, dt); check("R10 restart", dt, 9);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule